// File: doc/BRIEF.md
# Warp Pending Request Table

This block records outstanding memory instructions one warp instruction at a time, rather than one memory block at a time. A warp load arrives as one address per thread plus an active-thread mask. If the mask is not empty, the table claims a free entry for the instruction and stores the warp number and each thread's byte offset inside its target block. A splitter then walks the active threads. In each cycle it picks the lowest-numbered thread still waiting, gathers every other waiting thread whose address falls in the same block, and sends one request downward. The request carries the block address, the entry number and a mask of the threads it serves.

Responses come back carrying the entry number and the thread mask. Each response lowers that entry's pending-request count. In the same cycle, the block presents the stored offsets of the responding threads, so that logic outside the block can steer the returning data. When every request has been issued and every response has returned, the block pulses completion with the warp number and frees the entry. An instruction with no active thread completes at once and uses no entry.

Top module: `warp_pending_table`

## Requirements
- R1: After synchronous reset, req_valid and done_valid are low and in_ready is high.
- R2: A warp instruction with a non-zero mask is taken when in_valid and in_ready are both high. It claims the lowest-numbered free entry, and its first request appears in the following cycle with req_id equal to that entry number.
- R3: Each request has req_block equal to the address bits above the low OFF_W offset bits, and bit t of req_mask set exactly for the active threads t whose address lies in that block. The masks of one instruction do not overlap, and together they equal the active mask. Inactive threads never appear in any mask.
- R4: Requests go out one per cycle with no gaps. They are ordered by rising index of the lowest active thread that maps to each block.
- R5: in_ready stays low while requests of an accepted instruction are still being issued. It is high again in the first cycle with no request pending.
- R6: Each response lowers its entry's pending count by one. In the cycle after the response that brings the count to zero (with all requests issued), done_valid is high for exactly one cycle, done_warp holds the entry's warp number, and the entry becomes free.
- R7: While rsp_valid is high, lane t of wb_offs (bits t*OFF_W upward) holds the low OFF_W address bits that thread t had in the instruction held by entry rsp_id when rsp_mask bit t is set. Otherwise the lane is zero.
- R8: When every entry is in use, an instruction with a non-zero mask sees in_ready low and produces no request.
- R9: An instruction with an all-zero mask is taken whenever no requests are being issued and rsp_valid is low, even if the table is full. It claims no entry, and done_valid with its warp number follows in the next cycle. While rsp_valid is high, in_ready is low for such an instruction.
- R10: Entries complete independently in any order. A freed entry is the first one claimed by the next instruction when it is the lowest free entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Warp instruction offered |
| in_ready | output | 1 | Instruction can be taken this cycle |
| in_warp | input | WARP_W | Warp number of the instruction |
| in_mask | input | THREADS | Active-thread mask, bit t is thread t |
| in_addr | input | THREADS*ADDR_W | Per-thread byte addresses, thread t in bits t*ADDR_W upward |
| req_valid | output | 1 | Lower-level request valid |
| req_block | output | ADDR_W-OFF_W | Block address of the request |
| req_id | output | log2(ENTRIES) | Entry the request belongs to |
| req_mask | output | THREADS | Threads served by the request |
| rsp_valid | input | 1 | Response returning |
| rsp_id | input | log2(ENTRIES) | Entry of the response |
| rsp_mask | input | THREADS | Threads served by the response |
| wb_offs | output | THREADS*OFF_W | Block offsets of the responding threads |
| done_valid | output | 1 | One-cycle completion pulse |
| done_warp | output | WARP_W | Warp number that completed |

## Verification
On every cycle, the assertions check that two requests issued back to back never share a thread and keep to rising lowest-thread order. They also check that in_ready is low while requests are being issued or the table is full, that at most one entry finishes per cycle, that no response reaches an entry with nothing pending, and that an empty-mask instruction is followed by its completion pulse. Only the bench scenarios can show the actual block grouping for the address patterns used: all threads in one block, every thread in its own block, interleaved blocks, and inactive threads that share a block with active ones. The same holds for the offsets presented on responses, for out-of-order completion across entries, and for reuse of the lowest freed entry.

// File: rtl/wpt_pkg.sv
package wpt_pkg;

    localparam int unsigned DEF_THREADS = 8;
    localparam int unsigned DEF_ENTRIES = 4;
    localparam int unsigned DEF_ADDR_W  = 16;
    localparam int unsigned DEF_OFF_W   = 4;
    localparam int unsigned DEF_WARP_W  = 5;

    // Index of the lowest set bit; zero when none is set.
    function automatic int unsigned first_one(input logic [63:0] v);
        int unsigned idx;
        idx = 0;
        for (int i = 63; i >= 0; i--) begin
            if (v[i]) idx = i;
        end
        return idx;
    endfunction

endpackage

// File: rtl/wpt_splitter.sv
module wpt_splitter #(
    parameter int unsigned THREADS = 8,
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned OFF_W   = 4,
    parameter int unsigned ID_W    = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load,
    input  logic [THREADS-1:0]          load_mask,
    input  logic [THREADS*ADDR_W-1:0]   load_addr,
    input  logic [ID_W-1:0]             load_id,
    output logic                        busy,
    output logic                        req_valid,
    output logic [ADDR_W-OFF_W-1:0]     req_block,
    output logic [ID_W-1:0]             req_id,
    output logic [THREADS-1:0]          req_mask,
    output logic                        req_last
);
    import wpt_pkg::*;

    localparam int unsigned IDX_W = $clog2(THREADS);
    localparam int unsigned BLK_W = ADDR_W - OFF_W;

    logic [THREADS-1:0] rem;
    logic [ADDR_W-1:0]  addr_q [THREADS];
    logic [ID_W-1:0]    id_q;
    logic [IDX_W-1:0]   lead;
    logic [BLK_W-1:0]   lead_blk;
    logic [THREADS-1:0] grp;

    always_comb begin
        lead     = IDX_W'(first_one(64'(rem)));
        lead_blk = addr_q[lead][ADDR_W-1:OFF_W];
        for (int t = 0; t < THREADS; t++) begin
            grp[t] = rem[t] && (addr_q[t][ADDR_W-1:OFF_W] == lead_blk);
        end
    end

    assign busy      = |rem;
    assign req_valid = busy;
    assign req_block = lead_blk;
    assign req_id    = id_q;
    assign req_mask  = grp;
    assign req_last  = (rem & ~grp) == '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem  <= '0;
            id_q <= '0;
        end else if (load) begin
            rem  <= load_mask;
            id_q <= load_id;
            for (int t = 0; t < THREADS; t++) begin
                addr_q[t] <= load_addr[t*ADDR_W +: ADDR_W];
            end
        end else if (busy) begin
            rem <= rem & ~grp;
        end
    end

    AST_REQ_DISJOINT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && $past(req_valid)) |-> ((req_mask & $past(req_mask)) == '0)); // R3

    AST_REQ_ORDER: assert property (@(posedge clk) disable iff (rst)
        (req_valid && $past(req_valid)) |->
        ((req_mask & (($past(req_mask) & (~$past(req_mask) + 1'b1)) - 1'b1)) == '0)); // R4

endmodule

// File: rtl/wpt_entry.sv
module wpt_entry #(
    parameter int unsigned THREADS = 8,
    parameter int unsigned OFF_W   = 4,
    parameter int unsigned WARP_W  = 5,
    parameter int unsigned CNT_W   = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       alloc,
    input  logic [WARP_W-1:0]          alloc_warp,
    input  logic [THREADS*OFF_W-1:0]   alloc_offs,
    input  logic                       issue,
    input  logic                       issue_last,
    input  logic                       rsp,
    output logic                       busy,
    output logic [WARP_W-1:0]          warp,
    output logic [THREADS*OFF_W-1:0]   offs,
    output logic                       finish
);
    logic             open_q;
    logic [CNT_W-1:0] cnt, cnt_n;

    always_comb begin
        cnt_n = cnt;
        if (issue && !rsp)      cnt_n = cnt + 1'b1;
        else if (!issue && rsp) cnt_n = cnt - 1'b1;
        finish = busy && rsp && (cnt_n == '0) && !(open_q && !issue_last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            open_q <= 1'b0;
            cnt    <= '0;
            warp   <= '0;
            offs   <= '0;
        end else if (alloc) begin
            busy   <= 1'b1;
            open_q <= 1'b1;
            cnt    <= '0;
            warp   <= alloc_warp;
            offs   <= alloc_offs;
        end else begin
            cnt <= cnt_n;
            if (issue_last) open_q <= 1'b0;
            if (finish)     busy   <= 1'b0;
        end
    end

    AST_RSP_HAS_PENDING: assert property (@(posedge clk) disable iff (rst)
        rsp |-> (busy && cnt != '0)); // R6

    AST_CNT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        issue |-> (cnt < CNT_W'(THREADS))); // R3

endmodule

// File: rtl/warp_pending_table.sv
module warp_pending_table #(
    parameter int unsigned THREADS = wpt_pkg::DEF_THREADS,
    parameter int unsigned ENTRIES = wpt_pkg::DEF_ENTRIES,
    parameter int unsigned ADDR_W  = wpt_pkg::DEF_ADDR_W,
    parameter int unsigned OFF_W   = wpt_pkg::DEF_OFF_W,
    parameter int unsigned WARP_W  = wpt_pkg::DEF_WARP_W,
    localparam int unsigned ID_W   = $clog2(ENTRIES),
    localparam int unsigned BLK_W  = ADDR_W - OFF_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [WARP_W-1:0]           in_warp,
    input  logic [THREADS-1:0]          in_mask,
    input  logic [THREADS*ADDR_W-1:0]   in_addr,
    output logic                        req_valid,
    output logic [BLK_W-1:0]            req_block,
    output logic [ID_W-1:0]             req_id,
    output logic [THREADS-1:0]          req_mask,
    input  logic                        rsp_valid,
    input  logic [ID_W-1:0]             rsp_id,
    input  logic [THREADS-1:0]          rsp_mask,
    output logic [THREADS*OFF_W-1:0]    wb_offs,
    output logic                        done_valid,
    output logic [WARP_W-1:0]           done_warp
);
    import wpt_pkg::*;

    localparam int unsigned CNT_W = $clog2(THREADS + 1);

    logic                      split_busy, req_last;
    logic                      zero_in, accept, load;
    logic [ENTRIES-1:0]        busy_v, fin_v;
    logic [ID_W-1:0]           alloc_id;
    logic [THREADS*OFF_W-1:0]  in_offs;
    logic [WARP_W-1:0]         warp_v [ENTRIES];
    logic [THREADS*OFF_W-1:0]  offs_v [ENTRIES];
    logic [WARP_W-1:0]         fin_warp;
    logic [THREADS*OFF_W-1:0]  sel_offs;

    assign zero_in  = (in_mask == '0);
    assign alloc_id = ID_W'(first_one(64'(~busy_v)));
    assign in_ready = !split_busy && (zero_in ? !rsp_valid : (busy_v != '1));
    assign accept   = in_valid && in_ready;
    assign load     = accept && !zero_in;

    always_comb begin
        for (int t = 0; t < THREADS; t++) begin
            in_offs[t*OFF_W +: OFF_W] = in_addr[t*ADDR_W +: OFF_W];
        end
    end

    wpt_splitter #(
        .THREADS(THREADS), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .ID_W(ID_W)
    ) u_split (
        .clk(clk), .rst(rst),
        .load(load), .load_mask(in_mask), .load_addr(in_addr), .load_id(alloc_id),
        .busy(split_busy),
        .req_valid(req_valid), .req_block(req_block), .req_id(req_id),
        .req_mask(req_mask), .req_last(req_last)
    );

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        wpt_entry #(
            .THREADS(THREADS), .OFF_W(OFF_W), .WARP_W(WARP_W), .CNT_W(CNT_W)
        ) u_ent (
            .clk(clk), .rst(rst),
            .alloc(load && alloc_id == ID_W'(e)),
            .alloc_warp(in_warp), .alloc_offs(in_offs),
            .issue(req_valid && req_id == ID_W'(e)),
            .issue_last(req_valid && req_last && req_id == ID_W'(e)),
            .rsp(rsp_valid && rsp_id == ID_W'(e)),
            .busy(busy_v[e]), .warp(warp_v[e]), .offs(offs_v[e]),
            .finish(fin_v[e])
        );
    end

    always_comb begin
        fin_warp = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (fin_v[e]) fin_warp = fin_warp | warp_v[e];
        end
        sel_offs = offs_v[rsp_id];
        for (int t = 0; t < THREADS; t++) begin
            wb_offs[t*OFF_W +: OFF_W] = (rsp_valid && rsp_mask[t]) ? sel_offs[t*OFF_W +: OFF_W] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_valid <= 1'b0;
            done_warp  <= '0;
        end else begin
            done_valid <= (accept && zero_in) || (fin_v != '0);
            done_warp  <= (accept && zero_in) ? in_warp : fin_warp;
        end
    end

    AST_ONE_FINISH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fin_v)); // R6

    AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (rst)
        ((busy_v == '1) && !zero_in) |-> !in_ready); // R8

    AST_SPLIT_HOLDS_INPUT: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !in_ready); // R5

    AST_ZERO_DONE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && zero_in) |=> (done_valid && done_warp == $past(in_warp))); // R9

endmodule

// File: tb/warp_pending_table_bench.sv
module warp_pending_table_bench;

    localparam int TH = 8, EN = 4, AW = 16, OW = 4, WW = 5, IW = 2, BW = AW - OW;

    typedef struct packed {
        logic [7:0]   m;
        logic [127:0] a;
        logic [4:0]   w;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{8'hFF, 128'h123E_123C_123A_1238_1236_1234_1232_1230, 5'd1},
        '{8'h0F, 128'h0A40_0A40_0A40_0A40_0A54_0A50_0A44_0A40, 5'd2},
        '{8'h0B, 128'h0A60_0A60_0A60_0A60_0A6F_0A60_0A68_0A64, 5'd3},
        '{8'hFF, 128'h1077_1066_1055_1044_1033_1022_1011_1000, 5'd4},
        '{8'hDE, 128'h400F_2009_2003_4002_3007_2001_3005_2000, 5'd5}
    };

    logic clk = 0, rst = 1;
    logic in_valid = 0, in_ready;
    logic [WW-1:0] in_warp = '0;
    logic [TH-1:0] in_mask = '0;
    logic [TH*AW-1:0] in_addr = '0;
    logic req_valid;
    logic [BW-1:0] req_block;
    logic [IW-1:0] req_id;
    logic [TH-1:0] req_mask;
    logic rsp_valid = 0;
    logic [IW-1:0] rsp_id = '0;
    logic [TH-1:0] rsp_mask = '0;
    logic [TH*OW-1:0] wb_offs;
    logic done_valid;
    logic [WW-1:0] done_warp;

    int total = 0, bad = 0;
    int n_exp;
    logic [BW-1:0] eb [TH];
    logic [TH-1:0] em [TH];

    always #5 clk = ~clk;

    warp_pending_table #(.THREADS(TH), .ENTRIES(EN), .ADDR_W(AW), .OFF_W(OW), .WARP_W(WW)) u_warp_pending_table (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_warp(in_warp),
        .in_mask(in_mask), .in_addr(in_addr), .req_valid(req_valid), .req_block(req_block),
        .req_id(req_id), .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_id(rsp_id),
        .rsp_mask(rsp_mask), .wb_offs(wb_offs), .done_valid(done_valid), .done_warp(done_warp)
    );

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected request list from the grouping rule of R3/R4.
    task automatic build(input logic [7:0] m, input logic [127:0] a);
        logic [7:0] rem;
        logic [BW-1:0] blk;
        logic [TH-1:0] g;
        int l;
        n_exp = 0;
        rem = m;
        while (rem != 0) begin
            l = 0;
            for (int t = TH - 1; t >= 0; t--) if (rem[t]) l = t;
            blk = a[l*AW+OW +: BW];
            g = '0;
            for (int t = 0; t < TH; t++) if (rem[t] && a[t*AW+OW +: BW] == blk) g[t] = 1'b1;
            eb[n_exp] = blk;
            em[n_exp] = g;
            n_exp++;
            rem = rem & ~g;
        end
    endtask

    function automatic logic [TH*OW-1:0] exp_offs(input logic [127:0] a, input logic [TH-1:0] m);
        logic [TH*OW-1:0] r;
        r = '0;
        for (int t = 0; t < TH; t++) if (m[t]) r[t*OW +: OW] = a[t*AW +: OW];
        return r;
    endfunction

    task automatic issue(input logic [7:0] m, input logic [127:0] a, input logic [4:0] w, input int exp_id);
        in_valid = 1; in_mask = m; in_addr = a; in_warp = w;
        #1;
        chk(in_ready == 1'b1, "R2 ready for instruction", 64'(in_ready), 1);
        tick;
        in_valid = 0;
        build(m, a);
        for (int k = 0; k < n_exp; k++) begin
            chk(req_valid == 1'b1, "R4 request each cycle", 64'(req_valid), 1);
            chk(req_block == eb[k], "R3 request block", 64'(req_block), 64'(eb[k]));
            chk(req_mask == em[k], "R3 R4 request mask", 64'(req_mask), 64'(em[k]));
            chk(req_id == IW'(exp_id), "R2 request entry", 64'(req_id), 64'(exp_id));
            chk(in_ready == 1'b0, "R5 held while issuing", 64'(in_ready), 0);
            tick;
        end
        chk(req_valid == 1'b0, "R3 no extra request", 64'(req_valid), 0);
    endtask

    task automatic respond(input int id, input logic [TH-1:0] m, input logic [127:0] a,
                           input bit last, input logic [4:0] w);
        rsp_valid = 1; rsp_id = IW'(id); rsp_mask = m;
        #1;
        chk(wb_offs == exp_offs(a, m), "R7 response offsets", 64'(wb_offs), 64'(exp_offs(a, m)));
        tick;
        rsp_valid = 0;
        chk(done_valid == last, "R6 completion pulse", 64'(done_valid), 64'(last));
        if (last) chk(done_warp == w, "R6 completion warp", 64'(done_warp), 64'(w));
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) tick;
        rst = 0;
        tick;
        in_mask = 8'h01;
        #1;
        chk(in_ready == 1'b1, "R1 ready after reset", 64'(in_ready), 1);
        chk(req_valid == 1'b0, "R1 no request after reset", 64'(req_valid), 0);
        chk(done_valid == 1'b0, "R1 no completion after reset", 64'(done_valid), 0);
        tick;

        // Vector walk: issue, then answer in reverse order.
        for (int v = 0; v < 5; v++) begin
            issue(VECS[v].m, VECS[v].a, VECS[v].w, 0);
            chk(in_ready == 1'b1, "R5 ready after last request", 64'(in_ready), 1);
            for (int k = n_exp - 1; k >= 0; k--) begin
                respond(0, em[k], VECS[v].a, k == 0, VECS[v].w);
            end
            tick;
            chk(done_valid == 1'b0, "R6 pulse lasts one cycle", 64'(done_valid), 0);
        end

        // Fill every entry with single-block instructions (offset e+1).
        for (int e = 0; e < EN; e++) begin
            issue(8'h01, 128'(16'h5001 + 16'(e * 17)), 5'(10 + e), e);
        end
        in_valid = 1; in_mask = 8'h01; in_addr = 128'h6000; in_warp = 5'd19;
        #1;
        chk(in_ready == 1'b0, "R8 refused when full", 64'(in_ready), 0);
        tick;
        chk(req_valid == 1'b0, "R8 no request when full", 64'(req_valid), 0);

        // Empty mask while full.
        in_mask = 8'h00; in_warp = 5'd20;
        #1;
        chk(in_ready == 1'b1, "R9 empty mask taken while full", 64'(in_ready), 1);
        tick;
        in_valid = 0;
        chk(done_valid == 1'b1, "R9 empty mask completes", 64'(done_valid), 1);
        chk(done_warp == 5'd20, "R9 empty mask warp", 64'(done_warp), 20);
        chk(req_valid == 1'b0, "R9 empty mask issues nothing", 64'(req_valid), 0);

        // Empty mask held off by a response; entry 2 completes out of order.
        in_valid = 1; in_mask = 8'h00; in_warp = 5'd21;
        rsp_valid = 1; rsp_id = 2'd2; rsp_mask = 8'h01;
        #1;
        chk(in_ready == 1'b0, "R9 empty mask waits on response", 64'(in_ready), 0);
        chk(wb_offs == 32'h3, "R7 offset of entry two", 64'(wb_offs), 3);
        tick;
        in_valid = 0; rsp_valid = 0;
        chk(done_valid == 1'b1, "R10 out-of-order completion", 64'(done_valid), 1);
        chk(done_warp == 5'd12, "R10 out-of-order warp", 64'(done_warp), 12);
        tick;

        // Freed entry two is the lowest free and is reused.
        issue(8'h03, 128'h0000_0000_0000_0000_0000_0000_7008_7004, 5'd14, 2);
        respond(1, 8'h01, 128'(16'h5012), 1'b1, 5'd11);
        respond(2, 8'h03, 128'h7008_7004, 1'b1, 5'd14);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule